// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves 32-bit data words between card-side FIFOs and system memory. It follows a linked list of four-word descriptors held in memory. Software writes the address of the first descriptor and then sets the enable bit in the mode register. The engine reads each descriptor and checks that it owns it. It moves the requested number of bytes, hands the descriptor back with the ownership bit cleared, and then moves on to the next descriptor. A descriptor flagged as last ends the walk.

Each descriptor has four words: a control/status word, a sizes word, a buffer pointer and a link word. In the control word, bit 31 is ownership (1 = the engine owns it), bit 4 is chain, bit 2 is last, and bit 1 suppresses the completion interrupt. The sizes word gives the buffer length in bytes in bits 12:0. The same data port serves both directions. A mode bit chooses whether words go from the receive FIFO into memory or from memory into the transmit FIFO. All memory traffic uses one request/acknowledge port.

Top module: `cdma_engine`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_req`, `rxf_pop` and `txf_push` are low.
- R2: Writing the mode register (offset 0x80) with bit 7 set and bit 0 clear while idle starts the walk. The engine reads the four descriptor words at the address held at offset 0x88, then at +4, +8 and +12.
- R3: If control word bit 31 is clear, no data moves and the status bit 1 (unavailable) is set. The engine stays busy with no memory or FIFO traffic. Writing 1 to status bit 1 fetches the same descriptor again.
- R4: Sizes-word bits 12:0 give a byte count, capped at 4096. This count moves as ceil(bytes/4) words at consecutive addresses starting from the buffer pointer. A count of zero moves nothing.
- R5: Once `mem_req` is raised, it stays high with address, write flag and write data unchanged until `mem_ack`.
- R6: Mode bit 4 selects the direction: 0 moves words from the receive FIFO to memory, and 1 moves words from memory to the transmit FIFO.
- R7: After its data, each descriptor's control word is written back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R8: A descriptor with bit 2 set ends the walk: status bit 2 is set and busy clears. Otherwise the next descriptor is at the link word if bit 4 is set, and at the current address +16 if it is not.
- R9: Writeback sets status bit 0 (completion) unless control bit 1 is set. The last descriptor always sets status bit 0. `irq` is the OR of status bits 2:0.
- R10: The status register (offset 0x8C) clears bits 2:0 where a 1 is written. Bit 3 reads as busy and cannot be written.
- R11: Writing mode bit 0 aborts any walk and clears the mode and status registers. Bit 0 reads 1 in the cycle after the write and 0 after that.
- R12: The descriptor base reads back in full. Mode bits 7, 4 and 1 read back as written. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of status bits 2:0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access done, read data valid |
| mem_rdata | input | 32 | Memory read data |
| rxf_valid | input | 1 | Receive FIFO holds a word |
| rxf_data | input | 32 | Receive FIFO head word |
| rxf_pop | output | 1 | Receive FIFO pop |
| txf_ready | input | 1 | Transmit FIFO has space |
| txf_data | output | 32 | Transmit FIFO word |
| txf_push | output | 1 | Transmit FIFO push |

## Verification
The bench uses the default parameters: 32-bit addresses, a 13-bit size field and a 4096-byte cap per descriptor. With the 13-bit field, a size of 5000 exceeds the cap, so the bench can check the clamp and a full 1024-word move that runs the beat counter from its top value. The walk covers these cases:
- chained and sequential links;
- a zero-length descriptor;
- a suppressed interrupt;
- a descriptor that is not owned, then a resume;
- an abort in mid-transfer.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    localparam int OFS_MODE = 'h80;
    localparam int OFS_BASE = 'h88;
    localparam int OFS_STAT = 'h8C;

    localparam int MODE_EN   = 7;
    localparam int MODE_DIR  = 4;
    localparam int MODE_FB   = 1;
    localparam int MODE_SRST = 0;

    localparam int CW_OWN   = 31;
    localparam int CW_CHAIN = 4;
    localparam int CW_LAST  = 2;
    localparam int CW_NOINT = 1;

    localparam int ST_DONE = 0;
    localparam int ST_UNAV = 1;
    localparam int ST_END  = 2;
    localparam int ST_BUSY = 3;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_FETCH,
        WK_RX_WAIT,
        WK_RX_WR,
        WK_TX_RD,
        WK_TX_PUSH,
        WK_WBACK,
        WK_SUSP
    } walk_st_e;
endpackage

// File: rtl/cdma_beat_cnt.sv
module cdma_beat_cnt #(
    parameter int SZW       = 13,
    parameter int MAX_BYTES = 4096
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [SZW-1:0] size_i,
    input  logic           dec_i,
    output logic           zero_o,
    output logic           last_o
);
    localparam int MAXW = MAX_BYTES / 4;
    localparam int CW   = $clog2(MAXW + 1);

    logic [CW-1:0]  cnt_d, cnt_q;
    logic [SZW-1:0] clamp;

    always_comb begin
        clamp = (32'(size_i) > MAX_BYTES) ? SZW'(MAX_BYTES) : size_i;
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'((32'(clamp) + 32'd3) >> 2);
        end else if (dec_i) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
    assign last_o = (cnt_q == CW'(1));

    a_r4_dec_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> !zero_o)
        else $error("beat decrement with empty count");
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
#(
    parameter int RAW = 8,
    parameter int AW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           walk_idle_i,
    input  logic           walk_susp_i,
    input  logic           done_set_i,
    input  logic           unav_set_i,
    input  logic           end_set_i,
    output logic           start_o,
    output logic           resume_o,
    output logic           srst_o,
    output logic           dir_o,
    output logic [AW-1:0]  base_o,
    output logic [2:0]     stat_o
);
    typedef struct packed {
        logic [7:0]    mode;
        logic [AW-1:0] base;
        logic [2:0]    stat;
        logic          srst;
        logic          start;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_mode, wr_base, wr_stat;
    logic [2:0] clr_mask;

    localparam logic [7:0] MODE_KEEP = 8'((1 << MODE_EN) | (1 << MODE_DIR) | (1 << MODE_FB));

    assign wr_mode = reg_we && (reg_addr == RAW'(OFS_MODE));
    assign wr_base = reg_we && (reg_addr == RAW'(OFS_BASE));
    assign wr_stat = reg_we && (reg_addr == RAW'(OFS_STAT));

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.srst  = 1'b0;
        clr_mask  = wr_stat ? reg_wdata[2:0] : 3'b000;
        if (r_q.srst) begin
            r_d.mode = '0;
            r_d.stat = '0;
        end else begin
            if (wr_mode) begin
                if (reg_wdata[MODE_SRST]) begin
                    r_d.mode = '0;
                    r_d.srst = 1'b1;
                end else begin
                    r_d.mode  = reg_wdata[7:0] & MODE_KEEP;
                    r_d.start = reg_wdata[MODE_EN] && walk_idle_i;
                end
            end
            if (wr_base) begin
                r_d.base = reg_wdata[AW-1:0];
            end
            r_d.stat = (r_q.stat & ~clr_mask) | {end_set_i, unav_set_i, done_set_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RAW'(OFS_MODE)) begin
            reg_rdata = {24'b0, r_q.mode} | {31'b0, r_q.srst};
        end else if (reg_addr == RAW'(OFS_BASE)) begin
            reg_rdata = 32'(r_q.base);
        end else if (reg_addr == RAW'(OFS_STAT)) begin
            reg_rdata = {28'b0, !walk_idle_i, r_q.stat};
        end
    end

    assign start_o  = r_q.start;
    assign resume_o = wr_stat && reg_wdata[ST_UNAV] && walk_susp_i && !r_q.srst;
    assign srst_o   = r_q.srst;
    assign dir_o    = r_q.mode[MODE_DIR];
    assign base_o   = r_q.base;
    assign stat_o   = r_q.stat;

    a_r11_srst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.srst |=> !r_q.srst)
        else $error("software reset did not clear");

    a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n || r_q.srst)
        r_q.start |=> !walk_idle_i)
        else $error("start did not leave idle");
endmodule

// File: rtl/cdma_walker.sv
module cdma_walker
    import cdma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           resume_i,
    input  logic           abort_i,
    input  logic           dir_i,
    input  logic [AW-1:0]  base_i,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ack,
    input  logic [31:0]    mem_rdata,
    input  logic           rxf_valid,
    input  logic [31:0]    rxf_data,
    output logic           rxf_pop,
    input  logic           txf_ready,
    output logic [31:0]    txf_data,
    output logic           txf_push,
    output logic           done_set_o,
    output logic           unav_set_o,
    output logic           end_set_o,
    output logic           idle_o,
    output logic           susp_o,
    output logic           cnt_load_o,
    output logic [SZW-1:0] cnt_size_o,
    output logic           cnt_dec_o,
    input  logic           cnt_zero_i,
    input  logic           cnt_last_i
);
    typedef struct packed {
        walk_st_e      st;
        logic [1:0]    idx;
        logic [AW-1:0] dptr;
        logic [AW-1:0] bptr;
        logic [AW-1:0] nxt;
        logic [31:0]   w0;
        logic [31:0]   data;
        logic          dir;
    } walk_t;

    walk_t w_d, w_q;

    assign cnt_size_o = mem_rdata[SZW-1:0];

    always_comb begin
        w_d        = w_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = w_q.bptr;
        mem_wdata  = w_q.data;
        rxf_pop    = 1'b0;
        txf_push   = 1'b0;
        done_set_o = 1'b0;
        unav_set_o = 1'b0;
        end_set_o  = 1'b0;
        cnt_load_o = 1'b0;
        cnt_dec_o  = 1'b0;
        unique case (w_q.st)
            WK_IDLE: begin
                if (start_i) begin
                    w_d.dptr = base_i;
                    w_d.idx  = 2'd0;
                    w_d.dir  = dir_i;
                    w_d.st   = WK_FETCH;
                end
            end
            WK_FETCH: begin
                mem_req   = 1'b1;
                mem_addr  = w_q.dptr + AW'({w_q.idx, 2'b00});
                mem_wdata = '0;
                if (mem_ack) begin
                    unique case (w_q.idx)
                        2'd0: begin
                            w_d.w0 = mem_rdata;
                            if (!mem_rdata[CW_OWN]) begin
                                unav_set_o = 1'b1;
                                w_d.st     = WK_SUSP;
                            end else begin
                                w_d.idx = 2'd1;
                            end
                        end
                        2'd1: begin
                            cnt_load_o = 1'b1;
                            w_d.idx    = 2'd2;
                        end
                        2'd2: begin
                            w_d.bptr = mem_rdata[AW-1:0];
                            w_d.idx  = 2'd3;
                        end
                        default: begin
                            w_d.nxt = mem_rdata[AW-1:0];
                            w_d.idx = 2'd0;
                            if (cnt_zero_i) begin
                                w_d.st = WK_WBACK;
                            end else if (w_q.dir) begin
                                w_d.st = WK_TX_RD;
                            end else begin
                                w_d.st = WK_RX_WAIT;
                            end
                        end
                    endcase
                end
            end
            WK_RX_WAIT: begin
                rxf_pop = rxf_valid;
                if (rxf_valid) begin
                    w_d.data = rxf_data;
                    w_d.st   = WK_RX_WR;
                end
            end
            WK_RX_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cnt_dec_o = 1'b1;
                    w_d.bptr  = w_q.bptr + AW'(4);
                    w_d.st    = cnt_last_i ? WK_WBACK : WK_RX_WAIT;
                end
            end
            WK_TX_RD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    w_d.data = mem_rdata;
                    w_d.st   = WK_TX_PUSH;
                end
            end
            WK_TX_PUSH: begin
                txf_push = txf_ready;
                if (txf_ready) begin
                    cnt_dec_o = 1'b1;
                    w_d.bptr  = w_q.bptr + AW'(4);
                    w_d.st    = cnt_last_i ? WK_WBACK : WK_TX_RD;
                end
            end
            WK_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = w_q.dptr;
                mem_wdata = w_q.w0 & ~(32'b1 << CW_OWN);
                if (mem_ack) begin
                    done_set_o = !w_q.w0[CW_NOINT] || w_q.w0[CW_LAST];
                    if (w_q.w0[CW_LAST]) begin
                        end_set_o = 1'b1;
                        w_d.st    = WK_IDLE;
                    end else begin
                        w_d.dptr = w_q.w0[CW_CHAIN] ? w_q.nxt : (w_q.dptr + AW'(16));
                        w_d.idx  = 2'd0;
                        w_d.st   = WK_FETCH;
                    end
                end
            end
            WK_SUSP: begin
                if (resume_i) begin
                    w_d.idx = 2'd0;
                    w_d.st  = WK_FETCH;
                end
            end
            default: w_d.st = WK_IDLE;
        endcase
        if (abort_i) begin
            w_d.st = WK_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: WK_IDLE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign txf_data = w_q.data;
    assign idle_o   = (w_q.st == WK_IDLE);
    assign susp_o   = (w_q.st == WK_SUSP);

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n || abort_i)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
        else $error("memory request changed before acknowledge");
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
    import cdma_pkg::*;
#(
    parameter int RAW       = 8,
    parameter int AW        = 32,
    parameter int SZW       = 13,
    parameter int MAX_BYTES = 4096
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ack,
    input  logic [31:0]    mem_rdata,
    input  logic           rxf_valid,
    input  logic [31:0]    rxf_data,
    output logic           rxf_pop,
    input  logic           txf_ready,
    output logic [31:0]    txf_data,
    output logic           txf_push
);
    logic           start, resume, srst, dir;
    logic [AW-1:0]  base;
    logic [2:0]     stat;
    logic           done_set, unav_set, end_set, walk_idle, walk_susp;
    logic           cnt_load, cnt_dec, cnt_zero, cnt_last;
    logic [SZW-1:0] cnt_size;

    cdma_regs #(.RAW(RAW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .walk_idle_i(walk_idle), .walk_susp_i(walk_susp),
        .done_set_i(done_set), .unav_set_i(unav_set), .end_set_i(end_set),
        .start_o(start), .resume_o(resume), .srst_o(srst), .dir_o(dir),
        .base_o(base), .stat_o(stat)
    );

    cdma_walker #(.AW(AW), .SZW(SZW)) walker_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .resume_i(resume), .abort_i(srst), .dir_i(dir), .base_i(base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rxf_valid(rxf_valid), .rxf_data(rxf_data), .rxf_pop(rxf_pop),
        .txf_ready(txf_ready), .txf_data(txf_data), .txf_push(txf_push),
        .done_set_o(done_set), .unav_set_o(unav_set), .end_set_o(end_set),
        .idle_o(walk_idle), .susp_o(walk_susp),
        .cnt_load_o(cnt_load), .cnt_size_o(cnt_size), .cnt_dec_o(cnt_dec),
        .cnt_zero_i(cnt_zero), .cnt_last_i(cnt_last)
    );

    cdma_beat_cnt #(.SZW(SZW), .MAX_BYTES(MAX_BYTES)) cnt_i (
        .clk(clk), .rst_n(rst_n),
        .load_i(cnt_load), .size_i(cnt_size), .dec_i(cnt_dec),
        .zero_o(cnt_zero), .last_o(cnt_last)
    );

    assign irq = |stat;

    a_r3_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_UNAV] |-> (!mem_req && !rxf_pop && !txf_push))
        else $error("traffic while descriptor unavailable");
endmodule

// File: tb/cdma_engine_tb_top.sv
`timescale 1ns/1ps
module cdma_engine_tb_top;
    localparam int RAW = 8;
    localparam int AW  = 32;
    localparam logic [7:0] A_MODE = 8'h80;
    localparam logic [7:0] A_BASE = 8'h88;
    localparam logic [7:0] A_STAT = 8'h8C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq, mem_req, mem_we, mem_ack, rxf_pop, txf_push;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, txf_data;
    logic [31:0] rx_val;

    always #4 clk = ~clk;

    cdma_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rxf_valid(1'b1), .rxf_data(rx_val), .rxf_pop(rxf_pop),
        .txf_ready(1'b1), .txf_data(txf_data), .txf_push(txf_push)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_wr = 0;
    bit sb_on = 1'b1;
    bit hold_bad = 1'b0;
    logic [31:0] exp_rx = 32'h1000_0000;
    logic [63:0] wq[$];
    logic [31:0] txq[$];
    logic [31:0] mem [logic [31:0]];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] peek(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory model: one-cycle acknowledge pulse per access
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata <= peek(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // receive FIFO model: incrementing pattern
    always @(posedge clk) begin
        if (!rst_n) rx_val <= 32'h1000_0000;
        else if (rxf_pop) rx_val <= rx_val + 1;
    end

    // monitor: compares produced writes and pushes against the scoreboard
    logic prev_pend = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_pend && !(mem_req && mem_addr == prev_addr)) hold_bad = 1'b1;
            prev_pend = mem_req && !mem_ack;
            prev_addr = mem_addr;
            if (mem_req && mem_ack && mem_we) begin
                n_wr++;
                if (sb_on) begin
                    if (wq.size() == 0) begin
                        check("R7 unexpected write", mem_addr, 32'hFFFF_FFFF);
                    end else begin
                        logic [63:0] e;
                        e = wq.pop_front();
                        check("R4/R7 write address", mem_addr, e[63:32]);
                        check("R6/R7 write data", mem_wdata, e[31:0]);
                    end
                end
            end
            if (txf_push && sb_on) begin
                if (txq.size() == 0) check("R6 unexpected push", txf_data, 32'hFFFF_FFFF);
                else check("R6 pushed word", txf_data, txq.pop_front());
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(logic [31:0] a, logic [31:0] w0, logic [31:0] w1,
                            logic [31:0] w2, logic [31:0] w3);
        mem[a] = w0; mem[a+4] = w1; mem[a+8] = w2; mem[a+12] = w3;
    endtask

    task automatic push_rx(logic [31:0] b, int n);
        for (int i = 0; i < n; i++) begin
            wq.push_back({b + 32'(4*i), exp_rx});
            exp_rx = exp_rx + 1;
        end
    endtask

    task automatic push_wb(logic [31:0] a, logic [31:0] d);
        wq.push_back({a, d});
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, s);
            if (!s[3]) return;
        end
        check("R8 walk finished", 32'h1, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_MODE, d); check("R1 mode", d, 0);
        rd(A_BASE, d); check("R1 base", d, 0);
        rd(A_STAT, d); check("R1 status", d, 0);
        check("R1 irq/req", {29'b0, irq, mem_req, rxf_pop | txf_push}, 0);

        // R12 readback
        wr(A_BASE, 32'hDEAD_BEE0); rd(A_BASE, d); check("R12 base", d, 32'hDEAD_BEE0);
        wr(A_MODE, 32'h0000_0002); rd(A_MODE, d); check("R12 mode fixed-burst", d, 32'h2);
        rd(8'h40, d); check("R12 unmapped", d, 0);

        // Chained receive walk (R2 R4 R7 R8 R9)
        put_desc(32'h1000, 32'h8000_001A, 32'd10, 32'h4000, 32'h1100);
        put_desc(32'h1100, 32'h8000_0010, 32'd8, 32'h5000, 32'h1200);
        put_desc(32'h1200, 32'h8000_0004, 32'd4 | (32'd7 << 13), 32'h6000, 32'h0000_DEAD);
        push_rx(32'h4000, 3); push_wb(32'h1000, 32'h0000_001A);
        push_rx(32'h5000, 2); push_wb(32'h1100, 32'h0000_0010);
        push_rx(32'h6000, 1); push_wb(32'h1200, 32'h0000_0004);
        wr(A_BASE, 32'h1000);
        wr(A_MODE, 32'h80);
        wait_idle();
        check("R8 chain walk drained", wq.size(), 0);
        rd(A_STAT, d); check("R8 R9 status end+done", d, 32'h5);
        check("R9 irq high", {31'b0, irq}, 1);
        check("R7 own cleared in memory", peek(32'h1100), 32'h10);
        wr(A_STAT, 32'h1); rd(A_STAT, d); check("R10 partial clear", d, 32'h4);
        wr(A_STAT, 32'hC); rd(A_STAT, d); check("R10 clear, busy not writable", d, 0);
        check("R10 irq low", {31'b0, irq}, 0);

        // Not-owned descriptor, suppressed interrupt, resume (R3 R9)
        put_desc(32'h2000, 32'h8000_0012, 32'd4, 32'h7000, 32'h2100);
        put_desc(32'h2100, 32'h0000_0004, 32'd4, 32'h7100, 32'h0);
        push_rx(32'h7000, 1); push_wb(32'h2000, 32'h12);
        wr(A_BASE, 32'h2000);
        wr(A_MODE, 32'h80);
        d = 0;
        for (int i = 0; i < 200 && !d[1]; i++) rd(A_STAT, d);
        check("R3 R9 suspended, no completion", d, 32'hA);
        w0 = n_wr;
        repeat (20) @(negedge clk);
        check("R3 no traffic while suspended", n_wr, w0);
        check("R3 queue drained", wq.size(), 0);
        mem[32'h2100] = 32'h8000_0004;
        push_rx(32'h7100, 1); push_wb(32'h2100, 32'h4);
        wr(A_STAT, 32'h2);
        wait_idle();
        rd(A_STAT, d); check("R3 resumed to end", d, 32'h5);
        check("R3 resumed data", wq.size(), 0);
        wr(A_STAT, 32'h7);

        // Transmit direction, sequential link (R6 R8)
        mem[32'h8000] = 32'hA0; mem[32'h8004] = 32'hA1;
        mem[32'h9000] = 32'hB0; mem[32'h9004] = 32'hB1;
        put_desc(32'h3000, 32'h8000_0000, 32'd8, 32'h8000, 32'hFFFF_FFF0);
        put_desc(32'h3010, 32'h8000_0004, 32'd6, 32'h9000, 32'h0);
        txq.push_back(32'hA0); txq.push_back(32'hA1);
        txq.push_back(32'hB0); txq.push_back(32'hB1);
        push_wb(32'h3000, 32'h0); push_wb(32'h3010, 32'h4);
        wr(A_BASE, 32'h3000);
        wr(A_MODE, 32'h90);
        wait_idle();
        check("R6 all words pushed", txq.size(), 0);
        check("R8 sequential link followed", wq.size(), 0);
        wr(A_STAT, 32'h7);

        // Zero length and 4096-byte cap (R4)
        put_desc(32'hA000, 32'h8000_0010, 32'd0, 32'hC000, 32'hA100);
        put_desc(32'hA100, 32'h8000_0004, 32'd5000, 32'h1_0000, 32'h0);
        push_wb(32'hA000, 32'h10);
        push_rx(32'h1_0000, 1024);
        push_wb(32'hA100, 32'h4);
        wr(A_BASE, 32'hA000);
        wr(A_MODE, 32'h80);
        wait_idle();
        check("R4 capped transfer drained", wq.size(), 0);
        check("R4 nothing past cap", peek(32'h1_1000), 0);
        check("R4 zero length left buffer", peek(32'hC000), 0);
        wr(A_STAT, 32'h7);

        // Software reset mid-transfer (R11)
        put_desc(32'hB000, 32'h8000_0004, 32'd4000, 32'h2_0000, 32'h0);
        sb_on = 1'b0;
        wr(A_BASE, 32'hB000);
        wr(A_MODE, 32'h80);
        repeat (60) @(negedge clk);
        rd(A_STAT, d); check("R11 busy before reset", d & 32'h8, 32'h8);
        wr(A_MODE, 32'h1);
        reg_addr = A_MODE;
        #1 check("R11 reset bit visible", reg_rdata, 32'h1);
        @(negedge clk);
        #1 check("R11 reset bit cleared", reg_rdata, 32'h0);
        rd(A_STAT, d); check("R11 status cleared, idle", d, 0);
        repeat (4) @(negedge clk);
        check("R11 engine quiet", {31'b0, mem_req}, 0);
        wq.delete();
        exp_rx = rx_val;
        sb_on = 1'b1;

        check("R5 request held until acknowledge", {31'b0, hold_bad}, 0);
        check("R7 scoreboard empty", wq.size() + txq.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule